// File: doc/BRIEF.md
# Control Register and Coprocessor Trap Unit

This unit holds a processor's system control state. It keeps four mode bits: task-switched, emulate-coprocessor, monitor-coprocessor and protection-enable. It also keeps the linear address of the latest page fault and the base address of the page directory. Software writes these through a single write port. A select field on that port picks one of three targets: the whole control word, a 16-bit status-word load path, or the directory base. A task-switch strobe sets the task-switched bit and supplies a new directory base. A page-fault strobe records the faulting address.

For each decoded instruction, the unit looks at the coprocessor-escape and WAIT class flags. In that same cycle it decides whether to raise the coprocessor-not-available exception, which uses vector 7. It also issues a one-cycle translation-cache flush pulse whenever the directory base is written, and exports the protection-enable bit as a mode flag.

Top module: `sysctl_unit`

## Requirements
- R1: After synchronous reset, the control word, fault address and directory base all read 0, `prot_mode` is 0 and `tlb_flush` is 0.
- R2: A `tsw_valid` strobe sets the task-switched bit to 1. If a control-word write in the same cycle carries a 0 for that bit, the strobe still wins.
- R3: In the cycle that `insn_esc` is high, `trap_req` is 1 and `trap_vec` is 7 whenever the task-switched or emulate bit is 1. Otherwise `trap_req` is 0 and `trap_vec` is 0.
- R4: In the cycle that `insn_wait` is high, `trap_req` is 1 only when both the monitor and task-switched bits are 1. The emulate bit has no effect on WAIT.
- R5: When `insn_esc` and `insn_wait` are both high, the escape rule alone decides the trap.
- R6: A write with `wr_sel`=0 loads the control word. Bit 3 is task-switched, bit 2 is emulate, bit 1 is monitor and bit 0 is protection-enable. All bits above bit 3 read as 0.
- R7: A write with `wr_sel`=1 (status-word load) loads bits 3..1 from the data and can set protection-enable but never clear it. A write with `wr_sel`=3 changes nothing.
- R8: `prot_mode` equals the stored protection-enable bit, starting in the cycle after the write that changes it.
- R9: A `pf_valid` strobe captures the full 32-bit `pf_addr`.
- R10: A write with `wr_sel`=2 stores bits 31..12 of the data as the directory base. Bits 11..0 always read as 0.
- R11: Every directory-base write through the port gives a one-cycle `tlb_flush` pulse in the next cycle, even when the value is unchanged.
- R12: A task switch loads `tsw_base` into the directory base. It pulses `tlb_flush` only when bits 31..12 differ from the stored base.
- R13: `rd_data` is registered. It shows, one cycle after `rd_sel` is applied, the control word (0), the fault address (1), the directory base (2) or zero (3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control word, 1 status-word load, 2 directory base, 3 none |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read source: 0 control, 1 fault address, 2 directory base, 3 zero |
| rd_data | output | 32 | Registered read data |
| tsw_valid | input | 1 | Task-switch strobe |
| tsw_base | input | 32 | Directory base for the incoming task |
| pf_valid | input | 1 | Page-fault strobe |
| pf_addr | input | 32 | Faulting linear address |
| insn_esc | input | 1 | Current instruction is a coprocessor escape |
| insn_wait | input | 1 | Current instruction is WAIT |
| trap_req | output | 1 | Coprocessor-not-available request |
| trap_vec | output | 8 | Exception vector, 7 while trap_req is high |
| tlb_flush | output | 1 | One-cycle translation-cache flush |
| prot_mode | output | 1 | Protection-enable state |

## Verification
If a mode bit is stored wrongly, the fault shows up at `trap_req` in the very next instruction cycle that carries an escape or WAIT flag. It also appears in the control word one cycle after that word is selected for reading. If the directory-base comparison is wrong, the fault appears as a missing or extra `tlb_flush` in the cycle right after the task switch. If the status-word load path clears protection-enable, `prot_mode` drops one cycle after that load.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  typedef struct packed {
    logic ts;
    logic em;
    logic mp;
    logic pe;
  } mode_t;

  typedef enum logic [1:0] {
    WS_CTRL = 2'd0,
    WS_MSW  = 2'd1,
    WS_BASE = 2'd2,
    WS_NONE = 2'd3
  } wsel_t;

  typedef enum logic [1:0] {
    RS_CTRL  = 2'd0,
    RS_FAULT = 2'd1,
    RS_BASE  = 2'd2,
    RS_ZERO  = 2'd3
  } rsel_t;

endpackage

// File: rtl/sysctl_modereg.sv
module sysctl_modereg
  import sysctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       full_we,
  input  logic       msw_we,
  input  logic [3:0] wdata,
  input  logic       tsw,
  output mode_t      mode_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
    end else begin
      if (full_we) begin
        mode_q <= mode_t'(wdata);
      end else if (msw_we) begin
        mode_q.ts <= wdata[3];
        mode_q.em <= wdata[2];
        mode_q.mp <= wdata[1];
        mode_q.pe <= mode_q.pe | wdata[0];
      end
      if (tsw) begin
        mode_q.ts <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sysctl_capreg.sv
module sysctl_capreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (cap) q <= din;
  end

endmodule

// File: rtl/sysctl_pdbase.sv
module sysctl_pdbase #(
  parameter int AW = 32,
  parameter int PS = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wdata,
  input  logic          tsw,
  input  logic [AW-1:0] tsw_base,
  output logic [AW-1:0] base_q,
  output logic          flush_q
);

  localparam int HI = AW - PS;

  logic [HI-1:0] frame_q;
  logic          changed;

  assign changed = tsw && (tsw_base[AW-1:PS] != frame_q);
  assign base_q  = {frame_q, {PS{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '0;
      flush_q <= 1'b0;
    end else begin
      if (tsw)     frame_q <= tsw_base[AW-1:PS];
      else if (we) frame_q <= wdata[AW-1:PS];
      flush_q <= we | changed;
    end
  end

endmodule

// File: rtl/sysctl_cptrap.sv
module sysctl_cptrap
  import sysctl_pkg::*;
#(
  parameter int VW  = 8,
  parameter int VEC = 7
) (
  input  mode_t         mode,
  input  logic          esc,
  input  logic          wt,
  output logic          trap,
  output logic [VW-1:0] vec
);

  always_comb begin
    if (esc) trap = mode.ts | mode.em;
    else     trap = wt & mode.mp & mode.ts;
    vec = trap ? VW'(VEC) : '0;
  end

endmodule

// File: rtl/sysctl_unit.sv
module sysctl_unit
  import sysctl_pkg::*;
#(
  parameter int AW  = 32,
  parameter int PS  = 12,
  parameter int VW  = 8,
  parameter int VEC = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic [1:0]    rd_sel,
  output logic [AW-1:0] rd_data,
  input  logic          tsw_valid,
  input  logic [AW-1:0] tsw_base,
  input  logic          pf_valid,
  input  logic [AW-1:0] pf_addr,
  input  logic          insn_esc,
  input  logic          insn_wait,
  output logic          trap_req,
  output logic [VW-1:0] trap_vec,
  output logic          tlb_flush,
  output logic          prot_mode
);

  localparam int MB = $bits(mode_t);

  mode_t         mode_q;
  logic [AW-1:0] fault_q;
  logic [AW-1:0] base_q;
  logic [AW-1:0] ctrl_word;
  logic          full_we, msw_we, base_we;

  assign full_we = wr_en && (wsel_t'(wr_sel) == WS_CTRL);
  assign msw_we  = wr_en && (wsel_t'(wr_sel) == WS_MSW);
  assign base_we = wr_en && (wsel_t'(wr_sel) == WS_BASE);

  sysctl_modereg u_mode (
    .clk(clk), .rst(rst), .full_we(full_we), .msw_we(msw_we),
    .wdata(wr_data[MB-1:0]), .tsw(tsw_valid), .mode_q(mode_q)
  );

  sysctl_capreg #(.W(AW)) u_fault (
    .clk(clk), .rst(rst), .cap(pf_valid), .din(pf_addr), .q(fault_q)
  );

  sysctl_pdbase #(.AW(AW), .PS(PS)) u_base (
    .clk(clk), .rst(rst), .we(base_we), .wdata(wr_data),
    .tsw(tsw_valid), .tsw_base(tsw_base), .base_q(base_q), .flush_q(tlb_flush)
  );

  sysctl_cptrap #(.VW(VW), .VEC(VEC)) u_trap (
    .mode(mode_q), .esc(insn_esc), .wt(insn_wait), .trap(trap_req), .vec(trap_vec)
  );

  assign ctrl_word = {{(AW-MB){1'b0}}, mode_q};
  assign prot_mode = mode_q.pe;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rsel_t'(rd_sel))
        RS_CTRL:  rd_data <= ctrl_word;
        RS_FAULT: rd_data <= fault_q;
        RS_BASE:  rd_data <= base_q;
        default:  rd_data <= '0;
      endcase
    end
  end

endmodule

// File: rtl/sysctl_unit_chk.sv
module sysctl_unit_chk
  import sysctl_pkg::*;
#(
  parameter int AW  = 32,
  parameter int PS  = 12,
  parameter int VW  = 8,
  parameter int VEC = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic [AW-1:0] tsw_base,
  input logic          tsw_valid,
  input logic          pf_valid,
  input logic [AW-1:0] pf_addr,
  input logic          insn_esc,
  input logic          insn_wait,
  input logic          trap_req,
  input logic [VW-1:0] trap_vec,
  input logic          tlb_flush,
  input logic          prot_mode,
  input mode_t         mode_q,
  input logic [AW-1:0] fault_q,
  input logic [AW-1:0] base_q
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!prot_mode && !tlb_flush && fault_q == '0));

  a_r2_tsw_sets_ts: assert property (@(posedge clk) disable iff (rst)
    tsw_valid |=> mode_q.ts);

  a_r3_esc_em_trap: assert property (@(posedge clk) disable iff (rst)
    (insn_esc && mode_q.em) |-> (trap_req && trap_vec == VW'(VEC)));

  a_r4_wait_quiet: assert property (@(posedge clk) disable iff (rst)
    (insn_wait && !insn_esc && !(mode_q.mp && mode_q.ts)) |-> !trap_req);

  a_r7_msw_keeps_pe: assert property (@(posedge clk) disable iff (rst)
    (prot_mode && wr_en && wr_sel == 2'd1) |=> prot_mode);

  a_r9_fault_capture: assert property (@(posedge clk) disable iff (rst)
    pf_valid |=> (fault_q == $past(pf_addr)));

  a_r11_flush_on_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd2) |=> tlb_flush);

  a_r12_no_flush_same: assert property (@(posedge clk) disable iff (rst)
    (tsw_valid && !(wr_en && wr_sel == 2'd2) && tsw_base[AW-1:PS] == base_q[AW-1:PS])
      |=> !tlb_flush);

endmodule

bind sysctl_unit sysctl_unit_chk #(.AW(AW), .PS(PS), .VW(VW), .VEC(VEC)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .tsw_base(tsw_base),
  .tsw_valid(tsw_valid), .pf_valid(pf_valid), .pf_addr(pf_addr),
  .insn_esc(insn_esc), .insn_wait(insn_wait), .trap_req(trap_req),
  .trap_vec(trap_vec), .tlb_flush(tlb_flush), .prot_mode(prot_mode),
  .mode_q(mode_q), .fault_q(fault_q), .base_q(base_q)
);

// File: tb/sysctl_unit_tb_top.sv
module sysctl_unit_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic [1:0]  rd_sel;
  logic [31:0] rd_data;
  logic        tsw_valid;
  logic [31:0] tsw_base;
  logic        pf_valid;
  logic [31:0] pf_addr;
  logic        insn_esc, insn_wait;
  logic        trap_req;
  logic [7:0]  trap_vec;
  logic        tlb_flush;
  logic        prot_mode;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_unit dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .tsw_valid(tsw_valid), .tsw_base(tsw_base),
    .pf_valid(pf_valid), .pf_addr(pf_addr), .insn_esc(insn_esc), .insn_wait(insn_wait),
    .trap_req(trap_req), .trap_vec(trap_vec), .tlb_flush(tlb_flush), .prot_mode(prot_mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_sel = 2'd3; wr_data = '0; rd_sel = 2'd3;
    tsw_valid = 0; tsw_base = '0; pf_valid = 0; pf_addr = '0;
    insn_esc = 0; insn_wait = 0;
  endtask

  // drive at negedge, commit at posedge, return at following negedge
  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_sel = 2'd3;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    @(negedge clk);
    rd_sel = sel;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic trap_chk(input string req, input logic e, input logic w, input logic exp);
    @(negedge clk);
    insn_esc = e; insn_wait = w;
    #1;
    chk(req, {31'd0, trap_req}, {31'd0, exp});
    chk(req, {24'd0, trap_vec}, exp ? 32'd7 : 32'd0);
    insn_esc = 0; insn_wait = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rst = 1; idle();
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 prot_mode", {31'd0, prot_mode}, 0);
    chk("R1 flush", {31'd0, tlb_flush}, 0);
    rd(2'd0, v); chk("R1 ctrl", v, 0);
    rd(2'd1, v); chk("R1 fault", v, 0);
    rd(2'd2, v); chk("R1 base", v, 0);
    trap_chk("R3 no trap after reset", 1, 0, 0);
  endtask

  task automatic t_control();
    logic [31:0] v;
    wr(2'd0, 32'hFFFF_FFF5);
    rd(2'd0, v); chk("R6 ctrl upper zero", v, 32'h5);
    chk("R8 prot_mode set", {31'd0, prot_mode}, 1);
    trap_chk("R3 esc with EM", 1, 0, 1);
    trap_chk("R4 wait ignores EM", 0, 1, 0);
    wr(2'd0, 32'h0000_000A);
    trap_chk("R4 wait MP&TS", 0, 1, 1);
    trap_chk("R3 esc with TS", 1, 0, 1);
    trap_chk("R5 both flags", 1, 1, 1);
    chk("R8 prot_mode cleared", {31'd0, prot_mode}, 0);
    wr(2'd0, 32'h0000_0002);
    trap_chk("R4 wait MP only", 0, 1, 0);
    trap_chk("R3 esc clear", 1, 0, 0);
    trap_chk("R5 both flags quiet", 1, 1, 0);
    wr(2'd0, 32'h0000_0008);
    trap_chk("R4 wait TS only", 0, 1, 0);
  endtask

  task automatic t_msw();
    logic [31:0] v;
    wr(2'd0, 32'h1);
    wr(2'd1, 32'h0);
    rd(2'd0, v); chk("R7 msw keeps PE", v, 32'h1);
    wr(2'd1, 32'hFFF0_000E);
    rd(2'd0, v); chk("R7 msw bits", v, 32'hF);
    wr(2'd0, 32'h0);
    chk("R8 cleared by full", {31'd0, prot_mode}, 0);
    wr(2'd1, 32'h1);
    chk("R7 msw sets PE", {31'd0, prot_mode}, 1);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd0, v); chk("R7 sel3 no effect", v, 32'h1);
  endtask

  task automatic t_fault();
    logic [31:0] v;
    @(negedge clk); pf_valid = 1; pf_addr = 32'hDEAD_BEEF;
    @(negedge clk); pf_valid = 0;
    rd(2'd1, v); chk("R9 fault addr", v, 32'hDEAD_BEEF);
    @(negedge clk); pf_valid = 1; pf_addr = 32'h1234_5677;
    @(negedge clk); pf_valid = 0;
    rd(2'd1, v); chk("R9 fault addr 2", v, 32'h1234_5677);
    rd(2'd3, v); chk("R13 zero select", v, 0);
  endtask

  task automatic t_base();
    logic [31:0] v;
    wr(2'd2, 32'h1234_5ABC);
    chk("R11 flush on write", {31'd0, tlb_flush}, 1);
    @(negedge clk);
    chk("R11 flush one cycle", {31'd0, tlb_flush}, 0);
    rd(2'd2, v); chk("R10 base low zero", v, 32'h1234_5000);
    wr(2'd2, 32'h1234_5000);
    chk("R11 flush unchanged", {31'd0, tlb_flush}, 1);
    wr(2'd0, 32'h0);
    @(negedge clk); tsw_valid = 1; tsw_base = 32'h1234_5FFF;
    @(negedge clk); tsw_valid = 0;
    chk("R12 no flush same base", {31'd0, tlb_flush}, 0);
    rd(2'd0, v); chk("R2 tsw sets TS", v, 32'h8);
    @(negedge clk); tsw_valid = 1; tsw_base = 32'h0000_8123;
    @(negedge clk); tsw_valid = 0;
    chk("R12 flush new base", {31'd0, tlb_flush}, 1);
    rd(2'd2, v); chk("R12 base loaded", v, 32'h0000_8000);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    wr(2'd0, 32'h0);
    @(negedge clk);
    wr_en = 1; wr_sel = 2'd0; wr_data = 32'h3;
    tsw_valid = 1; tsw_base = 32'h0000_8000;
    @(negedge clk);
    wr_en = 0; wr_sel = 2'd3; tsw_valid = 0;
    rd(2'd0, v); chk("R2 tsw beats write", v, 32'hB);
    trap_chk("R13 read then trap", 1, 0, 1);
  endtask

  initial begin
    t_reset();
    t_control();
    t_msw();
    t_fault();
    t_base();
    t_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule